// File: doc/BRIEF.md
# MII Management Frame Engine

This block drives the management side of an MII link toward one or more attached PHYs. From the system clock it derives the management clock MDC with a programmable divider, and it shifts complete management read or write frames out on MDIO. The line is modelled as a split output, output enable and input, so the pad's tri-state buffer sits directly outside the block.

Software programs a 6-bit speed value N and a preamble-skip bit. It then presents one frame command with an operation (read or write), a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The engine raises `busy` for the whole frame. It reports completion with a one-cycle `done` pulse, and on a read it presents the 16 captured data bits on `rd_data` at that same moment.

Top module: `mii_mgmt_engine`

## Requirements
- R1: With speed value N > 0 held constant, MDC is high for exactly N system clocks and low for exactly N system clocks, giving a period of 2·N clocks.
- R2: While the speed value is 0, MDC stays low once it is low, and it is low within N clocks of the value being cleared.
- R3: A command presented while the speed value is 0 is dropped. `busy` stays low and MDIO stays released, even after the speed value later becomes nonzero.
- R4: A change of speed value is taken at the next MDC edge. The half-period in progress finishes with the old value, and the following half uses the new value.
- R5: When `skip_preamble` is 0, a frame is 64 MDC cycles long and its first 32 bits are ones. When it is 1, the frame is 32 MDC cycles long and begins directly with the start pattern.
- R6: After any preamble the frame bits are, MSB first: start `01`, operation `01` (write) or `10` (read), PHY address (5 bits), register address (5 bits), turnaround `10` for writes, then 16 data bits.
- R7: MDIO output and its enable change only while MDC goes low and are stable throughout every MDC high phase. The bench's PHY model samples on rising MDC.
- R8: On a read, the output enable is dropped for the turnaround and the 16 data bits (the last 18 bit times). `rd_data` holds the 16 bits sampled on the rising MDC edges of the data field, first-sampled bit as MSB.
- R9: `busy` is high from the clock after an accepted command until the rising MDC edge of the last bit. Then `done` pulses for exactly one clock, with `busy` low and MDIO released. A command offered while busy is ignored.
- R10: After reset MDC is low, `mdio_oe`, `busy` and `done` are low.
- R11: Clearing the speed value right after `done` leaves the completed frame and `rd_data` intact and parks MDC low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_div | input | 6 | MDC half-period in system clocks; 0 stops MDC |
| skip_preamble | input | 1 | 1 omits the 32-bit preamble |
| cmd_valid | input | 1 | Start request, taken when idle and speed_div is nonzero |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid when done pulses |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions assume that the speed value is only cleared while no frame is in flight, because a zero value mid-frame would stall the shift sequence. They also assume that `mdio_i` comes from a PHY that changes it only while MDC is low. The bench respects both. It changes the speed value only between frames, or in a dedicated edge test with no command pending, and its PHY model updates `mdio_i` just after each observed falling MDC edge.

// File: rtl/mii_mgmt_pkg.sv
// Package: shared constants and state encoding of the MII management engine.
// Assumes the standard clause-22 frame: 32-bit preamble, 32-bit body.
package mii_mgmt_pkg;
    localparam int PRE_BITS   = 32;
    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_WR     = 2'b01;
    localparam logic [1:0] OP_RD     = 2'b10;
    localparam logic [1:0] TA_WR     = 2'b10;
    localparam logic [1:0] TA_RD     = 2'b11;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ALIGN = 2'd1,
        SEQ_SHIFT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mdc_divider.sv
// Module: mdc_divider
// Derives MDC from clk. Each half-period lasts 'half_len' clocks, where the
// length is latched from speed_div at every MDC edge, so a change takes
// effect only at the next edge. A latched length of zero parks MDC low.
// Emits one-clock strobes in the cycle in which MDC rises or falls.
module mdc_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] speed_div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] half_len;
    logic [DIV_W-1:0] cnt;
    logic             edge_pt;

    // Purpose: flag the last clock of the current half-period.
    always_comb begin
        edge_pt  = (half_len != '0) && (cnt == half_len - DIV_W'(1));
        rise_stb = edge_pt && !mdc && (speed_div != '0);
        fall_stb = edge_pt && mdc;
    end

    // Purpose: count clocks in the half-period and toggle MDC at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc      <= 1'b0;
            cnt      <= '0;
            half_len <= '0;
        end else if (half_len == '0) begin
            mdc      <= 1'b0;
            cnt      <= '0;
            half_len <= speed_div;
        end else if (edge_pt) begin
            cnt      <= '0;
            half_len <= speed_div;
            mdc      <= (speed_div == '0) ? 1'b0 : !mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mii_frame_pack.sv
// Module: mii_frame_pack
// Combinational assembly of a full management frame, preamble first, MSB of
// the returned vector sent first. For reads the data field is zero and the
// turnaround is filled with ones; both are sent with the driver released.
module mii_frame_pack
    import mii_mgmt_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    localparam int FRAME_W = PRE_BITS + 6 + PHY_W + REG_W + DATA_W
) (
    input  logic               is_read,
    input  logic [PHY_W-1:0]   phy_addr,
    input  logic [REG_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame
);
    // Purpose: concatenate the frame fields in transmit order.
    always_comb begin
        frame = {{PRE_BITS{1'b1}}, START_PAT,
                 is_read ? OP_RD : OP_WR,
                 phy_addr, reg_addr,
                 is_read ? TA_RD : TA_WR,
                 is_read ? {DATA_W{1'b0}} : wdata};
    end
endmodule

// File: rtl/mii_shift_seq.sv
// Module: mii_shift_seq
// Serialises one frame. A command is taken only when idle and the clock is
// enabled. Each bit is presented at a falling MDC strobe and completed at the
// following rising strobe, where read data bits are also sampled. Assumes
// the divider keeps running until the frame ends.
module mii_shift_seq
    import mii_mgmt_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    localparam int FRAME_W = PRE_BITS + 6 + PHY_W + REG_W + DATA_W,
    localparam int IDX_W   = $clog2(FRAME_W + 1),
    localparam int REL_POS = PRE_BITS + 4 + PHY_W + REG_W,
    localparam int DAT_POS = REL_POS + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_enabled,
    input  logic               skip_pre,
    input  logic               start,
    input  logic               is_read,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mdio_o,
    output logic               mdio_oe
);
    seq_state_e         state;
    logic [FRAME_W-1:0] sh_q;
    logic [IDX_W-1:0]   pos;
    logic [DATA_W-1:0]  rd_sh;
    logic               rd_q;
    logic [IDX_W-1:0]   next_pos;

    // Purpose: position of the bit that the next falling strobe presents.
    always_comb next_pos = pos + IDX_W'(1);

    // Purpose: frame state machine, bit shifter and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            sh_q    <= '0;
            pos     <= '0;
            rd_sh   <= '0;
            rd_q    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start && clk_enabled) begin
                        sh_q  <= skip_pre ? (frame_in << PRE_BITS) : frame_in;
                        pos   <= skip_pre ? IDX_W'(PRE_BITS) : '0;
                        rd_q  <= is_read;
                        busy  <= 1'b1;
                        state <= SEQ_ALIGN;
                    end
                end
                SEQ_ALIGN: begin
                    if (fall_stb) begin
                        mdio_o  <= sh_q[FRAME_W-1];
                        mdio_oe <= 1'b1;
                        sh_q    <= sh_q << 1;
                        state   <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (rise_stb) begin
                        if (rd_q && pos >= IDX_W'(DAT_POS))
                            rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
                        if (pos == IDX_W'(FRAME_W - 1)) begin
                            if (rd_q)
                                rd_data <= {rd_sh[DATA_W-2:0], mdio_i};
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            mdio_oe <= 1'b0;
                            state   <= SEQ_IDLE;
                        end
                    end else if (fall_stb) begin
                        pos     <= next_pos;
                        mdio_o  <= sh_q[FRAME_W-1];
                        mdio_oe <= !(rd_q && next_pos >= IDX_W'(REL_POS));
                        sh_q    <= sh_q << 1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mii_mgmt_engine.sv
// Module: mii_mgmt_engine (top)
// MII management engine: MDC divider, frame assembly and shift sequencer.
// MDIO is split into output, enable and input for an external pad buffer.
// Assumes speed_div is not cleared while a frame is in flight.
module mii_mgmt_engine
    import mii_mgmt_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  speed_div,
    input  logic              skip_preamble,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [PHY_W-1:0]  cmd_phy,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int FRAME_W = PRE_BITS + 6 + PHY_W + REG_W + DATA_W;

    logic               rise_stb;
    logic               fall_stb;
    logic               clk_enabled;
    logic [FRAME_W-1:0] frame;

    // Purpose: frames may only start while the divider is programmed.
    always_comb clk_enabled = (speed_div != '0);

    mdc_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_div(speed_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mii_frame_pack #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_pack (
        .is_read (cmd_read),
        .phy_addr(cmd_phy),
        .reg_addr(cmd_reg),
        .wdata   (cmd_wdata),
        .frame   (frame)
    );

    mii_shift_seq #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_enabled(clk_enabled),
        .skip_pre   (skip_preamble),
        .start      (cmd_valid),
        .is_read    (cmd_read),
        .frame_in   (frame),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );
endmodule

// File: rtl/mii_mgmt_engine_chk.sv
// Module: mii_mgmt_engine_chk
// Port-level protocol checks for mii_mgmt_engine, attached by bind.
// Assumes speed_div stays nonzero while busy.
module mii_mgmt_engine_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] speed_div,
    input logic             busy,
    input logic             done,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    // R2: a stopped clock stays low
    p_parked_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_div == '0 && !mdc) |=> !mdc);

    // R3: no frame starts while the divider is zero
    p_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && speed_div == '0) |=> !busy);

    // R7: MDIO is stable during each MDC high phase
    p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done arrives with the frame closed and the line released
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mdio_oe));

    // R9: done follows a busy frame
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9: MDIO is only driven inside a frame
    p_oe_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);
endmodule

bind mii_mgmt_engine mii_mgmt_engine_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .speed_div(speed_div),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/tb_mii_mgmt_engine.sv
// Bench for mii_mgmt_engine: vector table of frames, then directed tests.
module tb_mii_mgmt_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  speed_div = '0;
    logic        skip_preamble = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    mii_mgmt_engine dut (
        .clk(clk), .rst_n(rst_n), .speed_div(speed_div),
        .skip_preamble(skip_preamble), .cmd_valid(cmd_valid),
        .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Vector: [33:28] speed, [27] skip, [26] read, [25:21] phy, [20:16] reg,
    // [15:0] write data or PHY response data.
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {6'd1,  1'b0, 1'b0, 5'h1F, 5'h00, 16'hA55A},
        {6'd2,  1'b1, 1'b1, 5'h01, 5'h1F, 16'h8001},
        {6'd5,  1'b0, 1'b1, 5'h15, 5'h0A, 16'h3C96},
        {6'd3,  1'b1, 1'b0, 5'h00, 5'h15, 16'h0000},
        {6'd63, 1'b1, 1'b0, 5'h0A, 5'h11, 16'h1234},
        {6'd4,  1'b0, 1'b1, 5'h1F, 5'h1F, 16'h7E81}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Measure one high phase and the following low phase, in clocks.
    task automatic measure(output int hi, output int lo);
        int g = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (mdc !== 1'b0 && g < 400) begin @(negedge clk); g++; end
        while (mdc !== 1'b1 && g < 400) begin @(negedge clk); g++; end
        while (mdc === 1'b1 && g < 400) begin hi++; @(negedge clk); g++; end
        while (mdc === 1'b0 && g < 400) begin lo++; @(negedge clk); g++; end
    endtask

    // Issue one frame, act as the PHY, and check the serial stream.
    task automatic run_frame(input logic [5:0] spd, input logic skp,
                             input logic rd, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] dat);
        logic [63:0] fr;
        int tot, st, rcnt, pos, guard, bad_pre, bad_fld, bad_oe, bad_hold;
        logic prev, cur, p_o, p_oe, exp_oe, started, seen_done;
        speed_div = spd; skip_preamble = skp;
        fr = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra,
              2'b10, rd ? 16'h0 : dat};
        tot = skp ? 32 : 64; st = skp ? 32 : 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = ra;
        cmd_wdata = rd ? 16'hFFFF : dat;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy === 1'b1, "R9", "busy after accept", busy, 1);
        prev = mdc; p_o = mdio_o; p_oe = mdio_oe;
        started = 0; seen_done = 0; rcnt = 0; guard = 0;
        bad_pre = 0; bad_fld = 0; bad_oe = 0; bad_hold = 0;
        while (!seen_done && guard < 20000) begin
            @(negedge clk); guard++;
            cur = mdc;
            if (prev && cur && (mdio_o !== p_o || mdio_oe !== p_oe)) bad_hold++;
            if (prev && !cur) begin
                started = 1;
                pos = st + rcnt;
                mdio_i = (pos >= 48 && pos < 64) ? dat[63-pos] : 1'b1;
            end
            if (started && !prev && cur) begin
                if (rcnt < tot) begin
                    pos = st + rcnt;
                    exp_oe = !(rd && pos >= 46);
                    if (p_oe !== exp_oe) bad_oe++;
                    else if (exp_oe && p_o !== fr[63-pos]) begin
                        if (pos < 32) bad_pre++; else bad_fld++;
                    end
                end
                rcnt++;
            end
            if (done === 1'b1) begin
                seen_done = 1;
                check(rcnt == tot, "R5", "frame length", rcnt, tot);
                check(busy === 1'b0 && mdio_oe === 1'b0, "R9",
                      "busy/oe at done", {busy, mdio_oe}, 0);
                if (rd) check(rd_data === dat, "R8", "read data", rd_data, dat);
            end
            prev = cur; p_o = mdio_o; p_oe = mdio_oe;
        end
        check(seen_done, "R9", "done seen", seen_done, 1);
        check(bad_pre == 0, "R5", "preamble bits", bad_pre, 0);
        check(bad_fld == 0, "R6", "field bits", bad_fld, 0);
        check(bad_oe == 0, "R8", "output enable pattern", bad_oe, 0);
        check(bad_hold == 0, "R7", "change during MDC high", bad_hold, 0);
        @(negedge clk);
        check(done === 1'b0, "R9", "done width", done, 0);
        mdio_i = 1'b1;
    endtask

    initial begin
        int hi, lo;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(mdc === 1'b0, "R10", "mdc after reset", mdc, 0);
        check(mdio_oe === 1'b0, "R10", "oe after reset", mdio_oe, 0);
        check(busy === 1'b0 && done === 1'b0, "R10", "busy/done after reset",
              {busy, done}, 0);
        rst_n = 1'b1;

        // Table walk: R1 period, R5..R9 frame content
        for (int i = 0; i < NV; i++) begin
            speed_div = VEC[i][33:28];
            measure(hi, lo);
            check(hi == int'(VEC[i][33:28]) && lo == int'(VEC[i][33:28]), "R1",
                  "half periods", {hi[15:0], lo[15:0]},
                  {10'd0, VEC[i][33:28], 10'd0, VEC[i][33:28]});
            run_frame(VEC[i][33:28], VEC[i][27], VEC[i][26], VEC[i][25:21],
                      VEC[i][20:16], VEC[i][15:0]);
        end

        // R2: cleared speed parks MDC low
        speed_div = '0;
        repeat (70) @(negedge clk);
        begin
            int highs = 0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (mdc !== 1'b0) highs++;
            end
            check(highs == 0, "R2", "mdc while stopped", highs, 0);
        end

        // R3: a command with speed zero is dropped
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (busy !== 1'b0 || mdio_oe !== 1'b0) seen++;
            end
            speed_div = 6'd2;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (busy !== 1'b0 || mdio_oe !== 1'b0) seen++;
            end
            check(seen == 0, "R3", "activity after dropped command", seen, 0);
        end

        // R4: new speed waits for the next MDC edge
        speed_div = 6'd3;
        repeat (20) @(negedge clk);
        while (mdc !== 1'b0) @(negedge clk);
        while (mdc !== 1'b1) @(negedge clk);
        speed_div = 6'd8;
        hi = 0; lo = 0;
        while (mdc === 1'b1) begin hi++; @(negedge clk); end
        while (mdc === 1'b0) begin lo++; @(negedge clk); end
        check(hi == 3, "R4", "half in progress keeps old value", hi, 3);
        check(lo == 8, "R4", "next half uses new value", lo, 8);
        measure(hi, lo);
        check(hi == 8 && lo == 8, "R4", "steady at new value", {hi, lo}, {8, 8});

        // R11: clear speed right after done
        run_frame(6'd2, 1'b1, 1'b1, 5'h07, 5'h03, 16'hC3A5);
        speed_div = '0;
        repeat (10) @(negedge clk);
        begin
            int highs = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (mdc !== 1'b0) highs++;
            end
            check(highs == 0, "R11", "mdc parked after frame", highs, 0);
        end
        check(rd_data === 16'hC3A5, "R11", "read data kept", rd_data, 16'hC3A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule